// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking translation tables in memory. A request brings the virtual address, the base of the first-level table and a translation-enable bit. When translation is on, the walker reads a first-level entry from memory. Each of these entries covers a 1 MB region. A mapped region uses that one entry directly. A region that points to a page table needs a second read, which fetches a 4 KB page entry. When translation is off, the address passes through unchanged and no memory is read.

The result gives the physical address and the cacheable and bufferable flags. It also gives a write policy derived from those two flags, the domain number and the access-permission bits. If the walk cannot complete, the result instead reports a fault and the table level that faulted. The walker handles one translation at a time. Memory reads use a simple request/valid handshake. The result stays on the outputs until it is acknowledged.

Top module: `xlat_walker`

## Requirements
- R1: With `mmu_en` low when a request is accepted, `rsp_valid` rises on the next clock edge. `rsp_pa` equals the virtual address, all attribute outputs and `rsp_fault` are zero, and no memory read is issued.
- R2: With `mmu_en` high, the first read address is `{tbl_base[31:14], va[31:20], 2'b00}`, so `tbl_base[13:0]` is ignored. `mem_req` rises on the edge after acceptance. `mem_req` and `mem_addr` hold steady until a cycle with `mem_rvalid` high.
- R3: A first-level entry with type bits [1:0] = 2 (a 1 MB mapping) completes after exactly one read. The results are `rsp_pa = {d[31:20], va[19:0]}`, cacheable = d[3], bufferable = d[2] and domain = d[8:5]. The two permission bits d[11:10] are copied into all four 2-bit slots of `rsp_ap`.
- R4: A first-level entry with type 1 (page table) starts a second read at `{d[31:10], va[19:12], 2'b00}`. This read starts in the cycle after the first read's `mem_rvalid`, with `mem_req` kept high.
- R5: A second-level entry with type bits [1:0] = 2 gives `rsp_pa = {p[31:12], va[11:0]}`, cacheable = p[3], bufferable = p[2] and `rsp_ap` = p[11:4]. The domain comes from the first-level entry's bits [8:5].
- R6: A first-level type of 0 or 3 ends the walk after one read with `rsp_fault` = 1 and `rsp_fault_lvl` = 0. `rsp_pa` and all attributes are zero.
- R7: A second-level type other than 2 ends the walk with `rsp_fault` = 1 and `rsp_fault_lvl` = 1. `rsp_pa` and all attributes are zero.
- R8: `rsp_wpol` is 2 (write-back) when both cacheable and bufferable are set. It is 1 (write-through) when only cacheable is set, and 0 (uncached) otherwise.
- R9: `req_ready` is high only while no translation is in progress or waiting. A result holds steady while `rsp_valid` is high and `rsp_ack` is low. A request presented in the acknowledge cycle is taken no earlier than the following edge.
- R10: After reset, `req_ready` is 1 and `mem_req` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_va | input | 32 | Virtual address |
| mmu_en | input | 1 | Translation enable, sampled with the request |
| tbl_base | input | 32 | First-level table base, sampled with the request |
| mem_req | output | 1 | Memory read request, held until data returns |
| mem_addr | output | 32 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result available |
| rsp_ack | input | 1 | Result consumed |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_cacheable | output | 1 | Cacheable attribute |
| rsp_bufferable | output | 1 | Bufferable attribute |
| rsp_wpol | output | 2 | Write policy: 0 uncached, 1 write-through, 2 write-back |
| rsp_domain | output | 4 | Domain number |
| rsp_ap | output | 8 | Access-permission bits, four 2-bit slots |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_fault_lvl | output | 1 | Faulting level: 0 first, 1 second |

## Verification
The acknowledge of a finished result and the arrival of the next translation request can fall in the same cycle. The bench provokes this by queueing the next request with `req_valid` held high while the monitor delays `rsp_ack` for zero to two cycles. It then checks that the walker stays busy through the acknowledge edge. On the following cycle the walker must be idle with no read started, and the queued request must complete with its own expected result. The second read of a page-table walk also starts in the same cycle that the first read's data lands. Memory latencies of zero to three cycles exercise this overlap.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [1:0] {
      L1_FAULT   = 2'd0,
      L1_COARSE  = 2'd1,
      L1_SECTION = 2'd2,
      L1_FINE    = 2'd3
   } l1_kind_e;

   typedef enum logic [1:0] {
      WP_NONE  = 2'd0,
      WP_WTHRU = 2'd1,
      WP_WBACK = 2'd2
   } wpol_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_L1   = 2'd1,
      ST_L2   = 2'd2,
      ST_DONE = 2'd3
   } walk_st_e;

   localparam int AP_SLOTS   = 4;
   localparam int AP_W       = 2 * AP_SLOTS;
   localparam int DOM_W      = 4;
   localparam int BIT_C      = 3;
   localparam int BIT_B      = 2;
   localparam int DOM_LSB    = 5;
   localparam int SECT_AP_LSB = 10;
   localparam int PAGE_AP_LSB = 4;
   localparam logic [1:0] PAGE_SMALL = 2'd2;

   typedef struct packed {
      logic             c;
      logic             b;
      logic [DOM_W-1:0] dom;
      logic [AP_W-1:0]  ap;
   } attr_t;
endpackage

// File: rtl/xlat_l1_dec.sv
module xlat_l1_dec
   import xlat_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SECT_SHIFT = 20,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output l1_kind_e          kind,
   output logic [ADDR_W-1:0] sect_pa,
   output logic [ADDR_W-1:0] l2_addr,
   output attr_t             attr
);
   localparam int L2_IDX_W   = SECT_SHIFT - PAGE_SHIFT;
   localparam int L2_TB_LSB  = L2_IDX_W + 2;

   logic [AP_W-1:0] ap_rep;
   logic            unused_bits;

   assign kind    = l1_kind_e'(desc[1:0]);
   assign sect_pa = {desc[ADDR_W-1:SECT_SHIFT], va[SECT_SHIFT-1:0]};
   assign l2_addr = {desc[ADDR_W-1:L2_TB_LSB], va[SECT_SHIFT-1:PAGE_SHIFT], 2'b00};

   for (genvar g = 0; g < AP_SLOTS; g++) begin : g_ap_rep
      assign ap_rep[2*g +: 2] = desc[SECT_AP_LSB +: 2];
   end

   assign attr        = '{c: desc[BIT_C], b: desc[BIT_B],
                          dom: desc[DOM_LSB +: DOM_W], ap: ap_rep};
   assign unused_bits = ^{desc[9], desc[4], va[ADDR_W-1:SECT_SHIFT]};
endmodule

// File: rtl/xlat_l2_dec.sv
module xlat_l2_dec
   import xlat_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PAGE_SHIFT = 12
) (
   input  logic [ADDR_W-1:0] desc,
   input  logic [ADDR_W-1:0] va,
   output logic              is_page,
   output logic [ADDR_W-1:0] page_pa,
   output logic              c,
   output logic              b,
   output logic [AP_W-1:0]   ap
);
   logic unused_va;

   assign is_page   = (desc[1:0] == PAGE_SMALL);
   assign page_pa   = {desc[ADDR_W-1:PAGE_SHIFT], va[PAGE_SHIFT-1:0]};
   assign c         = desc[BIT_C];
   assign b         = desc[BIT_B];
   assign ap        = desc[PAGE_AP_LSB +: AP_W];
   assign unused_va = ^va[ADDR_W-1:PAGE_SHIFT];
endmodule

// File: rtl/xlat_wpol.sv
module xlat_wpol
   import xlat_pkg::*;
(
   input  logic  c,
   input  logic  b,
   output wpol_e pol
);
   always_comb begin
      if (c && b)  pol = WP_WBACK;
      else if (c)  pol = WP_WTHRU;
      else         pol = WP_NONE;
   end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SECT_SHIFT = 20,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   input  logic              mmu_en,
   input  logic [ADDR_W-1:0] tbl_base,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [ADDR_W-1:0] mem_rdata,
   output logic              rsp_valid,
   input  logic              rsp_ack,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_cacheable,
   output logic              rsp_bufferable,
   output logic [1:0]        rsp_wpol,
   output logic [DOM_W-1:0]  rsp_domain,
   output logic [AP_W-1:0]   rsp_ap,
   output logic              rsp_fault,
   output logic              rsp_fault_lvl
);
   localparam int L1_IDX_W   = ADDR_W - SECT_SHIFT;
   localparam int L1_TB_LSB  = L1_IDX_W + 2;

   initial begin
      assert (ADDR_W == 32) else $error("descriptor layout needs 32-bit addresses");
      assert (SECT_SHIFT > PAGE_SHIFT) else $error("region must exceed page");
      assert (PAGE_SHIFT >= 12) else $error("page entry attributes occupy bits [11:0]");
   end

   walk_st_e          st_q;
   logic [ADDR_W-1:0] va_q;
   logic [ADDR_W-1:0] addr_q;
   logic              mreq_q;
   logic [ADDR_W-1:0] pa_q;
   attr_t             res_q;
   logic              flt_q;
   logic              lvl_q;

   l1_kind_e          l1_kind;
   logic [ADDR_W-1:0] l1_sect_pa;
   logic [ADDR_W-1:0] l1_next;
   attr_t             l1_attr;
   logic              l2_ok;
   logic [ADDR_W-1:0] l2_pa;
   logic              l2_c;
   logic              l2_b;
   logic [AP_W-1:0]   l2_ap;
   wpol_e             pol;
   logic              unused_base;

   xlat_l1_dec #(.ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)) l1_dec_i (
      .desc(mem_rdata), .va(va_q), .kind(l1_kind), .sect_pa(l1_sect_pa),
      .l2_addr(l1_next), .attr(l1_attr)
   );

   xlat_l2_dec #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) l2_dec_i (
      .desc(mem_rdata), .va(va_q), .is_page(l2_ok), .page_pa(l2_pa),
      .c(l2_c), .b(l2_b), .ap(l2_ap)
   );

   xlat_wpol wpol_i (.c(res_q.c), .b(res_q.b), .pol(pol));

   assign unused_base = ^tbl_base[L1_TB_LSB-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         va_q   <= '0;
         addr_q <= '0;
         mreq_q <= 1'b0;
         pa_q   <= '0;
         res_q  <= '0;
         flt_q  <= 1'b0;
         lvl_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               va_q  <= req_va;
               flt_q <= 1'b0;
               lvl_q <= 1'b0;
               res_q <= '0;
               if (!mmu_en) begin
                  pa_q <= req_va;
                  st_q <= ST_DONE;
               end else begin
                  addr_q <= {tbl_base[ADDR_W-1:L1_TB_LSB], req_va[ADDR_W-1:SECT_SHIFT], 2'b00};
                  mreq_q <= 1'b1;
                  st_q   <= ST_L1;
               end
            end
            ST_L1: if (mem_rvalid) begin
               case (l1_kind)
                  L1_SECTION: begin
                     pa_q   <= l1_sect_pa;
                     res_q  <= l1_attr;
                     mreq_q <= 1'b0;
                     st_q   <= ST_DONE;
                  end
                  L1_COARSE: begin
                     addr_q    <= l1_next;
                     res_q.dom <= l1_attr.dom;
                     st_q      <= ST_L2;
                  end
                  default: begin
                     pa_q   <= '0;
                     flt_q  <= 1'b1;
                     lvl_q  <= 1'b0;
                     mreq_q <= 1'b0;
                     st_q   <= ST_DONE;
                  end
               endcase
            end
            ST_L2: if (mem_rvalid) begin
               mreq_q <= 1'b0;
               st_q   <= ST_DONE;
               if (l2_ok) begin
                  pa_q  <= l2_pa;
                  res_q <= '{c: l2_c, b: l2_b, dom: res_q.dom, ap: l2_ap};
               end else begin
                  pa_q  <= '0;
                  res_q <= '0;
                  flt_q <= 1'b1;
                  lvl_q <= 1'b1;
               end
            end
            default: if (rsp_ack) st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (st_q == ST_IDLE);
   assign rsp_valid      = (st_q == ST_DONE);
   assign mem_req        = mreq_q;
   assign mem_addr       = addr_q;
   assign rsp_pa         = pa_q;
   assign rsp_cacheable  = res_q.c;
   assign rsp_bufferable = res_q.b;
   assign rsp_wpol       = pol;
   assign rsp_domain     = res_q.dom;
   assign rsp_ap         = res_q.ap;
   assign rsp_fault      = flt_q;
   assign rsp_fault_lvl  = lvl_q;

   AST_BYPASS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !mmu_en |=> rsp_valid && !mem_req); // R1
   AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr)); // R2
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_pa == '0 && !rsp_cacheable && rsp_ap == '0); // R6
   AST_UNCACHED_POL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_cacheable |-> rsp_wpol == WP_NONE); // R8
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)); // R9
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid || mem_req |-> !req_ready); // R9
endmodule

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        mmu_en = 1'b0;
   logic [31:0] tbl_base = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic        rsp_ack = 1'b0;
   logic [31:0] rsp_pa;
   logic        rsp_cacheable, rsp_bufferable;
   logic [1:0]  rsp_wpol;
   logic [3:0]  rsp_domain;
   logic [7:0]  rsp_ap;
   logic        rsp_fault, rsp_fault_lvl;

   always #10 clk = ~clk;

   xlat_walker dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .mmu_en(mmu_en), .tbl_base(tbl_base),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
      .rsp_pa(rsp_pa), .rsp_cacheable(rsp_cacheable), .rsp_bufferable(rsp_bufferable),
      .rsp_wpol(rsp_wpol), .rsp_domain(rsp_domain), .rsp_ap(rsp_ap),
      .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl)
   );

   typedef struct packed {
      logic [2:0]  kind;   // 0 bypass, 1 region, 2 page, 3 L1 fault, 4 L2 fault
      logic [31:0] pa;
      logic        c, b;
      logic [3:0]  dom;
      logic [7:0]  ap;
      logic        flt, lvl;
      logic [1:0]  nf;
      logic [31:0] f0, f1;
   } exp_t;

   exp_t        exp_q[$];
   logic [31:0] fetch_q[$];
   logic [31:0] mem [logic [31:0]];
   int          nchk = 0, nerr = 0;
   int          lat = 0, hold_n = 0;
   bit          finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic string tag_of(input logic [2:0] k);
      case (k)
         3'd0: return "R1";
         3'd1: return "R3";
         3'd2: return "R5";
         3'd3: return "R6";
         default: return "R7";
      endcase
   endfunction

   function automatic exp_t mk(input logic [2:0] k, input logic [31:0] pa, input logic c,
                               input logic b, input logic [3:0] dom, input logic [7:0] ap,
                               input logic [1:0] nf, input logic [31:0] f0, input logic [31:0] f1);
      exp_t e;
      e.kind = k; e.pa = pa; e.c = c; e.b = b; e.dom = dom; e.ap = ap;
      e.flt = (k >= 3'd3); e.lvl = (k == 3'd4);
      e.nf = nf; e.f0 = f0; e.f1 = f1;
      return e;
   endfunction

   // memory responder
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (mem_rvalid) mem_rvalid = 1'b0;
         else if (mem_req) begin
            if (cnt >= lat) begin
               mem_rdata  = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
               mem_rvalid = 1'b1;
               fetch_q.push_back(mem_addr);
               cnt = 0;
            end else cnt++;
         end
      end
   end

   // driver
   task automatic go(input logic [31:0] va, input logic en, input logic [31:0] base, input exp_t e);
      exp_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_va = va; mmu_en = en; tbl_base = base;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!en) chk(rsp_valid && !mem_req, "R1 one-cycle bypass", {30'd0, rsp_valid, mem_req}, 32'h2);
      else     chk(mem_req && mem_addr == e.f0, "R2 first read address", mem_addr, e.f0);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid && rst_n) begin
            exp_t e;
            logic [31:0] pa0;
            logic [1:0]  wexp;
            string t;
            if (exp_q.size() == 0) begin
               chk(0, "R9 unexpected result", rsp_pa, 32'h0);
            end else begin
               e = exp_q.pop_front();
               t = tag_of(e.kind);
               wexp = (e.c && e.b) ? 2'd2 : (e.c ? 2'd1 : 2'd0);
               chk(rsp_pa == e.pa, {t, " pa"}, rsp_pa, e.pa);
               chk({rsp_cacheable, rsp_bufferable, rsp_domain, rsp_ap} == {e.c, e.b, e.dom, e.ap},
                   {t, " attributes"}, {18'd0, rsp_cacheable, rsp_bufferable, rsp_domain, rsp_ap},
                   {18'd0, e.c, e.b, e.dom, e.ap});
               chk(rsp_wpol == wexp, "R8 write policy", {30'd0, rsp_wpol}, {30'd0, wexp});
               chk({rsp_fault, rsp_fault_lvl} == {e.flt, e.lvl}, {t, " fault flags"},
                   {30'd0, rsp_fault, rsp_fault_lvl}, {30'd0, e.flt, e.lvl});
               chk(fetch_q.size() == int'(e.nf), (e.nf == 2) ? "R4 read count" : {t, " read count"},
                   fetch_q.size(), {30'd0, e.nf});
               if (e.nf == 2 && fetch_q.size() == 2)
                  chk(fetch_q[1] == e.f1, "R4 second read address", fetch_q[1], e.f1);
            end
            fetch_q.delete();
            pa0 = rsp_pa;
            for (int i = 0; i < hold_n; i++) begin
               @(negedge clk);
               chk(rsp_valid && rsp_pa == pa0 && !req_ready, "R9 result held", rsp_pa, pa0);
            end
            rsp_ack = 1'b1;
            chk(!req_ready, "R9 busy in ack cycle", {31'd0, req_ready}, 32'h0);
            @(negedge clk);
            rsp_ack = 1'b0;
            chk(req_ready && !rsp_valid && !mem_req, "R9 idle after ack, nothing taken",
                {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      finish_run();
   end

   initial begin
      // tables
      mem[32'h001030C4] = 32'h8A500CAE;   // region, C B, dom 5, AP 3
      mem[32'h00100008] = 32'h123005EA;   // region, C only, dom 15, AP 1
      mem[32'h00100FFC] = 32'h40000006;   // region, B only
      mem[32'h00103FFC] = 32'h00200061;   // page table at 0x00200000, dom 3
      mem[32'h002003BC] = 32'hFFFEFFFE;   // page C B, AP ff
      mem[32'h00200000] = 32'h0ABCD5AA;   // page C only, AP 5a
      mem[32'h00200008] = 32'h11111001;   // type 1 at second level
      mem[32'h00100014] = 32'h12345673;   // type 3 at first level
      mem[32'h00FFC004] = 32'h77700C02;   // region, no C B, AP 3

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !mem_req && !rsp_valid, "R10 reset state",
          {29'd0, req_ready, mem_req, rsp_valid}, 32'h4);

      lat = 0; hold_n = 0;
      go(32'hDEADBEEF, 0, 32'h00100000, mk(0, 32'hDEADBEEF, 0, 0, 0, 8'h00, 0, 0, 0));
      lat = 2; hold_n = 2;
      go(32'hC3123456, 1, 32'h00100000, mk(1, 32'h8A523456, 1, 1, 5, 8'hFF, 1, 32'h001030C4, 0));
      lat = 1; hold_n = 1;
      go(32'h00200010, 1, 32'h00100000, mk(1, 32'h12300010, 1, 0, 15, 8'h55, 1, 32'h00100008, 0));
      lat = 0; hold_n = 0;
      go(32'h3FF00001, 1, 32'h00100000, mk(1, 32'h40000001, 0, 1, 0, 8'h00, 1, 32'h00100FFC, 0));
      lat = 3; hold_n = 2;
      go(32'hFFFEF123, 1, 32'h00100000,
         mk(2, 32'hFFFEF123, 1, 1, 3, 8'hFF, 2, 32'h00103FFC, 32'h002003BC));
      lat = 0; hold_n = 0;
      go(32'hFFF00456, 1, 32'h00100000,
         mk(2, 32'h0ABCD456, 1, 0, 3, 8'h5A, 2, 32'h00103FFC, 32'h00200000));
      lat = 1; hold_n = 1;
      go(32'h00000000, 1, 32'h00100000, mk(3, 0, 0, 0, 0, 8'h00, 1, 32'h00100000, 0));
      go(32'h00500000, 1, 32'h00100000, mk(3, 0, 0, 0, 0, 8'h00, 1, 32'h00100014, 0));
      lat = 2; hold_n = 0;
      go(32'hFFF01000, 1, 32'h00100000, mk(4, 0, 0, 0, 0, 8'h00, 2, 32'h00103FFC, 32'h00200004));
      go(32'hFFF02000, 1, 32'h00100000, mk(4, 0, 0, 0, 0, 8'h00, 2, 32'h00103FFC, 32'h00200008));
      lat = 0; hold_n = 2;
      go(32'h00100000, 1, 32'h00FFDFFF, mk(1, 32'h77700000, 0, 0, 0, 8'hFF, 1, 32'h00FFC004, 0));
      hold_n = 0;
      go(32'h12345678, 0, 32'h00100000, mk(0, 32'h12345678, 0, 0, 0, 8'h00, 0, 0, 0));

      while (exp_q.size() != 0 || !req_ready) @(negedge clk);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule